// File: doc/BRIEF.md
# Clocked Non-Retriggerable One-Shot

This block is a digital monostable. Two trigger pins start a pulse. One responds to a falling edge and the other to a rising edge. Each trigger path is qualified by the level on the opposite pin. Once a pulse is running, every further trigger is locked out until the pulse has finished. A separate active-low clear pin stops a running pulse and holds the output low. Releasing the clear can itself start a pulse, but only after the trigger pins have gone through a preparation sequence while the clear was held.

The pulse length is a count of clock cycles, taken from `width_i` at the moment a trigger is accepted. The block drives a true output and a complementary output, both from flops. All three control pins pass through synchronizers before edge detection, so their timing is free relative to the clock. A dual part is two instances.

Top module: `oneshot_pulse`

## Requirements
- R1: A high-to-low change on `trig_fall_i` starts a pulse only if `trig_rise_i` is high and `clr_n_i` is high. A falling edge while `trig_rise_i` is low does nothing.
- R2: A low-to-high change on `trig_rise_i` starts a pulse only if `trig_fall_i` is low and `clr_n_i` is high. A rising edge while `trig_fall_i` is high does nothing.
- R3: An accepted trigger raises `pulse_o` for exactly W cycles, where W is the value on `width_i` at the cycle the trigger is accepted. Later changes to `width_i` do not alter a running pulse. Timing is fixed: if a pin changes between clock edges N-1 and N, `pulse_o` is high after edge N+2.
- R4: A trigger accepted while `width_i` is zero produces no pulse.
- R5: While a pulse runs, edges on either trigger pin have no effect. This includes a trigger whose acceptance would fall on the same edge at which the pulse ends.
- R6: A low on `clr_n_i` ends any pulse with the same fixed latency as a trigger. `pulse_o` then stays low and `pulse_n_o` high for as long as the clear stays low, whatever the trigger pins do.
- R7: A rising edge on `clr_n_i` starts a pulse if, at that moment, `trig_fall_i` is low and `trig_rise_i` is high, and if, while the clear was low, `trig_fall_i` was seen high or `trig_rise_i` was seen low.
- R8: Releasing `clr_n_i` with `trig_fall_i` low and `trig_rise_i` high all along starts no pulse. This also holds after the chip reset, so power-up with the clear low never fires on release.
- R9: With `trig_fall_i` held high, or `trig_rise_i` held low, and the clear high, the outputs rest at `pulse_o` low and no pulse occurs.
- R10: `pulse_n_o` is always the inverse of `pulse_o`.
- R11: While `rst_n` is low the block is idle: `pulse_o` is low and `pulse_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Chip reset, asynchronous assert, active low |
| width_i | input | WIDTH_W | Pulse length in clock cycles, captured on trigger |
| trig_fall_i | input | 1 | Trigger pin, fires on a falling edge |
| trig_rise_i | input | 1 | Trigger pin, fires on a rising edge |
| clr_n_i | input | 1 | Active-low clear; its release may also trigger |
| pulse_o | output | 1 | One-shot output, high during the pulse |
| pulse_n_o | output | 1 | Inverse of pulse_o |

## Verification
The trigger pins are driven through every edge-and-level pairing. A falling edge is applied with the other pin high and with it low, and a rising edge with the other pin low and with it high. These cases separate correct gating from a path that ignores its qualifier. Edge storms are injected during a long pulse, with the last one timed to be accepted exactly on the ending edge, which catches both a retriggering counter and an off-by-one in the lockout. Clear releases are applied with and without a preparation sequence and after a chip reset, which distinguishes a true armed release from a plain level trigger. Width changes during a pulse and a zero width show whether the length is captured at the right moment.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  // Bit positions of the synchronized pin vector
  localparam int unsigned PIN_FALL  = 0;
  localparam int unsigned PIN_RISE  = 1;
  localparam int unsigned PIN_CLR   = 2;
  localparam int unsigned PIN_COUNT = 3;

  // Which qualification path accepted a trigger
  typedef enum logic [1:0] {
    TRIG_NONE    = 2'd0,
    TRIG_FALL    = 2'd1,
    TRIG_RISE    = 2'd2,
    TRIG_RELEASE = 2'd3
  } trig_src_e;

endpackage

// File: rtl/os_rst_sync.sv
module os_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/os_sync.sv
module os_sync #(
  parameter int unsigned     N       = 3,
  parameter int unsigned     STAGES  = 2,
  parameter logic [N-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], d_i[i]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= {STAGES{RST_VAL[i]}};
      end else begin
        chain_q <= chain_d;
      end
    end

    assign q_o[i] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/os_trigger_qual.sv
module os_trigger_qual
  import oneshot_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fall_s_i,
  input  logic rise_s_i,
  input  logic clr_s_i,
  output logic fire_o
);

  logic      fall_d_q, rise_d_q, clr_d_q;
  logic      armed_q, armed_d;
  logic      fall_edge, rise_edge, clr_edge, pair_ready;
  trig_src_e src;

  always_comb begin
    fall_edge  = fall_d_q & ~fall_s_i;
    rise_edge  = ~rise_d_q & rise_s_i;
    clr_edge   = ~clr_d_q & clr_s_i;
    pair_ready = ~fall_s_i & rise_s_i;

    // Release priority first; both pin paths require the clear high
    if (!clr_s_i) begin
      src = TRIG_NONE;
    end else if (clr_edge && armed_q && pair_ready) begin
      src = TRIG_RELEASE;
    end else if (fall_edge && rise_s_i) begin
      src = TRIG_FALL;
    end else if (rise_edge && !fall_s_i) begin
      src = TRIG_RISE;
    end else begin
      src = TRIG_NONE;
    end

    // Arm while cleared once the pins leave the ready pair; disarm when clear is high
    if (clr_s_i) begin
      armed_d = 1'b0;
    end else begin
      armed_d = armed_q | fall_s_i | ~rise_s_i;
    end
  end

  assign fire_o = (src != TRIG_NONE);

  // Delay flops reset to the same idle levels as the synchronizers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_d_q <= 1'b0;
      rise_d_q <= 1'b1;
      clr_d_q  <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      fall_d_q <= fall_s_i;
      rise_d_q <= rise_s_i;
      clr_d_q  <= clr_s_i;
      armed_q  <= armed_d;
    end
  end

endmodule

// File: rtl/os_pulse_timer.sv
module os_pulse_timer #(
  parameter int unsigned WIDTH_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_s_i,
  input  logic               fire_i,
  input  logic [WIDTH_W-1:0] width_i,
  output logic [WIDTH_W-1:0] cnt_o,
  output logic               q_o,
  output logic               qn_o
);

  logic [WIDTH_W-1:0] cnt_q, cnt_d;
  logic               busy, cnt_en;
  logic               q_q, qn_q;

  always_comb begin
    busy   = (cnt_q != '0);
    cnt_en = !clr_s_i || busy || fire_i;
    if (!clr_s_i) begin
      cnt_d = '0;
    end else if (busy) begin
      cnt_d = cnt_q - 1'b1;      // lockout: a trigger is not looked at while busy
    end else if (fire_i) begin
      cnt_d = width_i;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      q_q   <= 1'b0;
      qn_q  <= 1'b1;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      q_q   <= (cnt_d != '0);
      qn_q  <= (cnt_d == '0);
    end
  end

  assign cnt_o = cnt_q;
  assign q_o   = q_q;
  assign qn_o  = qn_q;

endmodule

// File: rtl/oneshot_pulse.sv
module oneshot_pulse
  import oneshot_pkg::*;
#(
  parameter int unsigned WIDTH_W     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WIDTH_W-1:0] width_i,
  input  logic               trig_fall_i,
  input  logic               trig_rise_i,
  input  logic               clr_n_i,
  output logic               pulse_o,
  output logic               pulse_n_o
);

  localparam logic [PIN_COUNT-1:0] SYNC_RST = PIN_COUNT'(1 << PIN_RISE);

  logic                 rst_sync_n;
  logic [PIN_COUNT-1:0] pins_raw, pins_s;
  logic                 fall_s, rise_s, clr_s;
  logic                 fire;
  logic [WIDTH_W-1:0]   cnt_q;

  always_comb begin
    pins_raw           = '0;
    pins_raw[PIN_FALL] = trig_fall_i;
    pins_raw[PIN_RISE] = trig_rise_i;
    pins_raw[PIN_CLR]  = clr_n_i;
  end

  os_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  os_sync #(
    .N       (PIN_COUNT),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (SYNC_RST)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  assign fall_s = pins_s[PIN_FALL];
  assign rise_s = pins_s[PIN_RISE];
  assign clr_s  = pins_s[PIN_CLR];

  os_trigger_qual u_qual (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .fall_s_i (fall_s),
    .rise_s_i (rise_s),
    .clr_s_i  (clr_s),
    .fire_o   (fire)
  );

  os_pulse_timer #(.WIDTH_W(WIDTH_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr_s_i (clr_s),
    .fire_i  (fire),
    .width_i (width_i),
    .cnt_o   (cnt_q),
    .q_o     (pulse_o),
    .qn_o    (pulse_n_o)
  );

endmodule

// File: rtl/os_checker.sv
module os_checker #(
  parameter int unsigned WIDTH_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clr_q,
  input logic               fire,
  input logic [WIDTH_W-1:0] cnt_q,
  input logic [WIDTH_W-1:0] width_i,
  input logic               pulse_o,
  input logic               pulse_n_o
);

  p_clear_forces_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_q |=> (!pulse_o && pulse_n_o));

  p_no_fire_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_q |-> !fire);

  p_countdown_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && clr_q) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_load_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cnt_q == '0 && clr_q) |=> (cnt_q == $past(width_i)));

  p_q_matches_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o == (cnt_q != '0));

  p_zero_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cnt_q == '0 && width_i == '0) |=> !pulse_o);

  p_start_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(fire));

  p_complement_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_n_o != pulse_o);

endmodule

bind oneshot_pulse os_checker #(.WIDTH_W(WIDTH_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .clr_q     (clr_s),
  .fire      (fire),
  .cnt_q     (cnt_q),
  .width_i   (width_i),
  .pulse_o   (pulse_o),
  .pulse_n_o (pulse_n_o)
);

// File: tb/sim_oneshot_pulse.sv
module sim_oneshot_pulse;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] width;
  logic         a, b, clr_n;
  logic         pulse_o, pulse_n_o;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;

  typedef struct {
    int    start;
    int    len;
    string tag;
  } exp_t;
  exp_t sb[$];

  bit in_pulse = 1'b0;
  int st = 0;
  int ln = 0;

  oneshot_pulse #(.WIDTH_W(W)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .width_i     (width),
    .trig_fall_i (a),
    .trig_rise_i (b),
    .clr_n_i     (clr_n),
    .pulse_o     (pulse_o),
    .pulse_n_o   (pulse_n_o)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_pulse(input int start, input int len, input string tag);
    exp_t e;
    e.start = start;
    e.len   = len;
    e.tag   = tag;
    sb.push_back(e);
  endtask

  task automatic check_idle(input string tag);
    #1;
    check(pulse_o == 1'b0, tag, "pulse_o idle", int'(pulse_o), 0);
    check(pulse_n_o == 1'b1, tag, "pulse_n_o idle", int'(pulse_n_o), 1);
    check(sb.size() == 0, tag, "pending expected pulses", sb.size(), 0);
  endtask

  // Monitor: measures every pulse and compares against the scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      check(pulse_n_o == !pulse_o, "R10", "complement", int'(pulse_n_o), int'(!pulse_o));
    end
    if (pulse_o && !in_pulse) begin
      in_pulse = 1'b1;
      st = cyc;
      ln = 1;
    end else if (pulse_o) begin
      ln++;
    end else if (in_pulse) begin
      in_pulse = 1'b0;
      if (sb.size() == 0) begin
        check(1'b0, "R5", "unexpected pulse start", st, -1);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(st == e.start, e.tag, "pulse start", st, e.start);
        check(ln == e.len, e.tag, "pulse length", ln, e.len);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", "run time", cyc, 20000);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int c;
    a = 1'b1; b = 1'b0; clr_n = 1'b1; width = '0; rst_n = 1'b0;
    wait_n(3);
    // R11: reset state
    check(pulse_o == 1'b0, "R11", "pulse_o in reset", int'(pulse_o), 0);
    check(pulse_n_o == 1'b1, "R11", "pulse_n_o in reset", int'(pulse_n_o), 1);
    rst_n = 1'b1;
    wait_n(6);
    check_idle("R11");

    // R2: rising trig_rise with trig_fall high is gated
    b = 1'b1;
    wait_n(6);
    check_idle("R2");

    // R1: falling trig_fall with trig_rise high
    width = 8'd5; a = 1'b0; c = cyc;
    expect_pulse(c + 3, 5, "R1");
    wait_n(12);
    check_idle("R1");
    a = 1'b1; wait_n(3);
    b = 1'b0; wait_n(4);
    check_idle("R9");

    // R1: falling edge with trig_rise low is gated
    a = 1'b0;
    wait_n(6);
    check_idle("R1");
    a = 1'b1; wait_n(4);

    // R2: rising trig_rise with trig_fall low
    a = 1'b0; wait_n(4);
    width = 8'd3; b = 1'b1; c = cyc;
    expect_pulse(c + 3, 3, "R2");
    wait_n(10);
    check_idle("R2");
    a = 1'b1; wait_n(4);
    b = 1'b0; wait_n(4);
    b = 1'b1; wait_n(6);
    check_idle("R2");

    // R3: width captured at trigger, later change ignored
    width = 8'd6; a = 1'b0; c = cyc;
    expect_pulse(c + 3, 6, "R3");
    wait_n(4);
    width = 8'd1;
    wait_n(10);
    check_idle("R3");

    // R4: zero width gives nothing
    a = 1'b1; wait_n(4);
    width = 8'd0; a = 1'b0;
    wait_n(8);
    check_idle("R4");

    // R5: lockout, including a trigger landing on the ending edge
    b = 1'b0; wait_n(4);
    width = 8'd10; b = 1'b1; c = cyc;
    expect_pulse(c + 3, 10, "R5");
    wait_n(4); b = 1'b0;
    wait_n(1); b = 1'b1;
    wait_n(1); a = 1'b1;
    wait_n(1); a = 1'b0;
    wait_n(1); a = 1'b1;
    wait_n(2); a = 1'b0;
    wait_n(12);
    check_idle("R5");

    // R6: clear truncates and holds; R7: armed release fires
    width = 8'd20;
    a = 1'b1; wait_n(4);
    a = 1'b0; c = cyc;
    expect_pulse(c + 3, 8, "R6");
    wait_n(8);
    clr_n = 1'b0;
    wait_n(4);
    a = 1'b1; wait_n(2);
    a = 1'b0; wait_n(2);
    b = 1'b0; wait_n(2);
    b = 1'b1; wait_n(4);
    check_idle("R6");
    width = 8'd4; clr_n = 1'b1; c = cyc;
    expect_pulse(c + 3, 4, "R7");
    wait_n(10);
    check_idle("R7");

    // R8: release without preparation
    clr_n = 1'b0; wait_n(10);
    clr_n = 1'b1; wait_n(10);
    check_idle("R8");

    // R8: chip reset with clear low, then release
    rst_n = 1'b0; clr_n = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(6);
    clr_n = 1'b1;
    wait_n(10);
    check_idle("R8");

    // R9: one pin held at its blocking level while the other toggles
    a = 1'b1; wait_n(3);
    b = 1'b0; wait_n(3);
    b = 1'b1; wait_n(3);
    b = 1'b0; wait_n(3);
    a = 1'b0; wait_n(3);
    a = 1'b1; wait_n(3);
    a = 1'b0; wait_n(3);
    a = 1'b1; wait_n(6);
    check_idle("R9");

    wait_n(5);
    while (sb.size() != 0) begin
      exp_t e;
      e = sb.pop_front();
      check(1'b0, e.tag, "missing pulse at", 0, e.start);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule